// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block puts two caption or extended-data characters onto one video line per field. Software-side logic writes a byte pair for each field through a small write port. When the selected line begins, the block waits a programmable number of clocks and then produces a burst of luma sample levels. The burst holds a clock run-in, a three-bit start pattern and the two characters. While the burst lasts, `smp_vld` is high and the luma path takes `smp` in place of its normal picture data.

The bit rate is 32 times line frequency in both scan standards. A line is 1716 clocks in 525-line mode and 1728 clocks in 625-line mode, so a bit does not span a whole number of clocks. A phase accumulator steps in half-bit units, so the symbol edges fall on the ideal positions rounded up to the next clock and never drift. Each field keeps its own pending pair. If nothing new was written for a field, that field sends the null pair.

Top module: `cc_line_enc`

## Requirements
- R1: A burst is started only by a `line_start` pulse while `line_num` equals the caption line (21 when `std_625`=0, 22 when `std_625`=1) and `cap_en[fld]` is 1. Any other line number sends nothing.
- R2: If the starting `line_start` is sampled at clock edge E0, `smp_vld` is low up to and including edge E0+`start_ofs` and rises after edge E0+`start_ofs`+1.
- R3: The burst holds 52 half-bit symbols and lasts exactly 1395 clocks in 525-line mode and 1404 clocks in 625-line mode. `smp_vld` is low in the clock after the burst.
- R4: Half-bit edges come from a drift-free accumulator. Burst clock k (k=1 is the first) carries half-symbol floor(64*(k-1)/L), where L=1716 or 1728.
- R5: A bit value 1 is sent as level 560 and a bit value 0 as level 240. Outside the burst, `smp` is 0 and `smp_vld` is 0.
- R6: The symbol order is fixed. First come 14 half-bits alternating 1,0,... (seven run-in cycles, starting high). Next come the start bits 0,0,1. Then come the first character (`wr_data[7:0]`) and the second character (`wr_data[15:8]`), each sent LSB first. Each of these bits lasts two half-bits.
- R7: In each transmitted character, bit 7 is odd parity over bits 6:0. The written bit 7 is ignored.
- R8: A write (`wr_en`) stores a pair for field `wr_fld`. Pairs are latched when a burst is accepted. A write in the same clock as the latch for that field is not sent in that burst but in the next burst of that field.
- R9: If no pair was written for a field since its previous latch, that field's burst carries 0x80, 0x80.
- R10: With `cap_en[fld]`=0, the caption line produces no burst and a pending pair stays stored for a later enabled burst.
- R11: A `line_start` pulse during a burst is ignored; the burst length and content do not change.
- R12: After reset, `smp_vld` and `smp` are 0 and no pair is pending in either field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-clock pulse at the start of each line |
| line_num | input | 10 | Current line number in the field |
| fld | input | 1 | Field flag: 0 first field, 1 second field |
| std_625 | input | 1 | 0 selects 525-line timing, 1 selects 625-line timing |
| cap_en | input | 2 | Per-field caption enable, bit index equals field |
| start_ofs | input | 11 | Clocks from line start to burst start |
| wr_en | input | 1 | Store `wr_data` as the pending pair of `wr_fld` |
| wr_fld | input | 1 | Field that the write targets |
| wr_data | input | 16 | First character in [7:0], second in [15:8] |
| smp | output | 10 | Luma sample level during the burst, 0 otherwise |
| smp_vld | output | 1 | High while `smp` replaces picture data |

## Verification
A pair write and a pair latch can fall in the same clock. The bench provokes this by raising `wr_en` for field 1 in the same cycle as the accepted `line_start` for field 1. It judges the result from two bursts: the first must still carry the earlier pair, and the next field-1 burst must carry the colliding write. A second overlap is a new line pulse arriving while the accumulator is mid-burst. It is judged by a burst length and waveform that do not change.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SEND
    } cc_state_e;

    // burst layout in half-bit units
    localparam int CC_RUNIN_HALVES = 14;
    localparam int CC_FRAME_BITS   = 3;
    localparam int CC_DATA_BITS    = 16;
    localparam int CC_HALF_TOTAL   = CC_RUNIN_HALVES + 2 * (CC_FRAME_BITS + CC_DATA_BITS);
    localparam int CC_IDX_W        = $clog2(CC_HALF_TOTAL);

    // odd parity in bit 7 over bits 6:0
    function automatic logic [7:0] cc_add_parity(input logic [7:0] b);
        return {~(^b[6:0]), b[6:0]};
    endfunction

endpackage

// File: rtl/cc_bit_timer.sv
module cc_bit_timer #(
    parameter int LC_A = 1716,
    parameter int LC_B = 1728,
    parameter int STEP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_b,
    input  logic run_i,
    output logic tick_o
);
    localparam int LC_MAX = (LC_A > LC_B) ? LC_A : LC_B;
    localparam int ACC_W  = $clog2(LC_MAX + STEP + 1);

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W-1:0] lim, sum;

    always_comb begin
        lim    = sel_b ? ACC_W'(LC_B) : ACC_W'(LC_A);
        sum    = acc_q + ACC_W'(STEP);
        tick_o = 1'b0;
        acc_d  = '0;
        if (run_i) begin
            if (sum >= lim) begin
                tick_o = 1'b1;
                acc_d  = sum - lim;
            end else begin
                acc_d  = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R4: the remainder never reaches a whole line length
    a_r4_acc_below_line: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < lim);

endmodule

// File: rtl/cc_byte_bank.sv
module cc_byte_bank
    import cc_pkg::*;
#(
    parameter int FIELDS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_fld,
    input  logic [15:0] wr_data,
    input  logic        lat_en,
    input  logic        lat_fld,
    output logic [15:0] pair_o
);
    typedef struct packed {
        logic [FIELDS-1:0][15:0] pend;
        logic [FIELDS-1:0]       fresh;
        logic [15:0]             cur;
    } bank_t;

    bank_t st_d, st_q;
    logic [FIELDS-1:0][15:0] coded;

    generate
        for (genvar f = 0; f < FIELDS; f++) begin : g_code
            assign coded[f] = {cc_add_parity(st_q.pend[f][15:8]),
                               cc_add_parity(st_q.pend[f][7:0])};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (lat_en) begin
            st_d.cur           = st_q.fresh[lat_fld] ? coded[lat_fld] : 16'h8080;
            st_d.fresh[lat_fld] = 1'b0;
        end
        // a write in the latch cycle stays pending for the next burst
        if (wr_en) begin
            st_d.pend[wr_fld]  = wr_data;
            st_d.fresh[wr_fld] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= '0;
            st_q.fresh <= '0;
            st_q.cur   <= 16'h8080;
        end else begin
            st_q <= st_d;
        end
    end

    assign pair_o = st_q.cur;

    // R7: both latched characters carry odd parity
    a_r7_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (^st_q.cur[7:0]) && (^st_q.cur[15:8]));

    // R9: a latch without a colliding write consumes the pending pair
    a_r9_latch_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_en && !wr_en) |=> !st_q.fresh[$past(lat_fld)]);

endmodule

// File: rtl/cc_symbol_gen.sv
module cc_symbol_gen
    import cc_pkg::*;
#(
    parameter int          LVL_W  = 10,
    parameter logic [9:0]  LVL_LO = 10'd240,
    parameter logic [9:0]  LVL_HI = 10'd560
) (
    input  logic                active_i,
    input  logic [CC_IDX_W-1:0] idx_i,
    input  logic [15:0]         pair_i,
    output logic [LVL_W-1:0]    smp_o
);
    logic [CC_IDX_W-1:0] rel;
    logic [4:0]          bitn;
    logic [3:0]          dpos;
    logic                val;

    always_comb begin
        rel  = idx_i - CC_IDX_W'(CC_RUNIN_HALVES);
        bitn = 5'(rel >> 1);
        dpos = 4'(bitn - 5'(CC_FRAME_BITS));
        if (idx_i < CC_IDX_W'(CC_RUNIN_HALVES))
            val = ~idx_i[0];
        else if (bitn < 5'(CC_FRAME_BITS))
            val = (bitn == 5'(CC_FRAME_BITS - 1));
        else
            val = pair_i[dpos];
        smp_o = active_i ? (val ? LVL_W'(LVL_HI) : LVL_W'(LVL_LO)) : '0;
    end

endmodule

// File: rtl/cc_line_enc.sv
module cc_line_enc
    import cc_pkg::*;
#(
    parameter int          LINE_W    = 10,
    parameter int          OFS_W     = 11,
    parameter int          LVL_W     = 10,
    parameter int          CLKS_525  = 1716,
    parameter int          CLKS_625  = 1728,
    parameter int          BITS_LINE = 32,
    parameter int          CAP_L525  = 21,
    parameter int          CAP_L625  = 22,
    parameter logic [9:0]  LVL_LO    = 10'd240,
    parameter logic [9:0]  LVL_HI    = 10'd560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              fld,
    input  logic              std_625,
    input  logic [1:0]        cap_en,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic              wr_en,
    input  logic              wr_fld,
    input  logic [15:0]       wr_data,
    output logic [LVL_W-1:0]  smp,
    output logic              smp_vld
);
    localparam int HALF_STEP = 2 * BITS_LINE;

    typedef struct packed {
        cc_state_e           state;
        logic [OFS_W-1:0]    cnt;
        logic [CC_IDX_W-1:0] idx;
    } ctl_t;

    ctl_t        st_d, st_q;
    logic        accept;
    logic        tick;
    logic        sending;
    logic [15:0] pair;
    logic [LINE_W-1:0] tgt_line;

    assign tgt_line = std_625 ? LINE_W'(CAP_L625) : LINE_W'(CAP_L525);
    assign sending  = (st_q.state == ST_SEND);

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (line_start && (line_num == tgt_line) && cap_en[fld]) begin
                    accept     = 1'b1;
                    st_d.state = ST_WAIT;
                    st_d.cnt   = '0;
                end
            end
            ST_WAIT: begin
                if (st_q.cnt == start_ofs) begin
                    st_d.state = ST_SEND;
                    st_d.idx   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (tick) begin
                    if (st_q.idx == CC_IDX_W'(CC_HALF_TOTAL - 1))
                        st_d.state = ST_IDLE;
                    else
                        st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    cc_bit_timer #(
        .LC_A (CLKS_525),
        .LC_B (CLKS_625),
        .STEP (HALF_STEP)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_b  (std_625),
        .run_i  (sending),
        .tick_o (tick)
    );

    cc_byte_bank #(
        .FIELDS (2)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_fld  (wr_fld),
        .wr_data (wr_data),
        .lat_en  (accept),
        .lat_fld (fld),
        .pair_o  (pair)
    );

    cc_symbol_gen #(
        .LVL_W  (LVL_W),
        .LVL_LO (LVL_LO),
        .LVL_HI (LVL_HI)
    ) sym_i (
        .active_i (sending),
        .idx_i    (st_q.idx),
        .pair_i   (pair),
        .smp_o    (smp)
    );

    assign smp_vld = sending;

    // R5: only the two data levels appear inside the burst
    a_r5_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> (smp == LVL_W'(LVL_LO) || smp == LVL_W'(LVL_HI)));

    // R5: outside the burst the sample is zero
    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |-> (smp == '0));

    // R2: the burst opens only after the offset wait
    a_r2_open_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_vld) |-> $past(st_q.state == ST_WAIT));

    // R3: the last half-bit edge closes the burst
    a_r3_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st_q.idx == CC_IDX_W'(CC_HALF_TOTAL - 1)) |=> !smp_vld);

endmodule

// File: tb/cc_line_enc_tb_top.sv
module cc_line_enc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [9:0]  line_num = 10'd0;
    logic        fld = 1'b0;
    logic        std_625 = 1'b1;
    logic [1:0]  cap_en = 2'b11;
    logic [10:0] start_ofs = 11'd0;
    logic        wr_en = 1'b0;
    logic        wr_fld = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [9:0]  smp;
    logic        smp_vld;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    cc_line_enc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_num   (line_num),
        .fld        (fld),
        .std_625    (std_625),
        .cap_en     (cap_en),
        .start_ofs  (start_ofs),
        .wr_en      (wr_en),
        .wr_fld     (wr_fld),
        .wr_data    (wr_data),
        .smp        (smp),
        .smp_vld    (smp_vld)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
            $finish;
        end
    end

    function automatic logic [7:0] par8(input logic [7:0] b);
        return {~(^b[6:0]), b[6:0]};
    endfunction

    function automatic logic [15:0] enc_pair(input logic [15:0] raw);
        return {par8(raw[15:8]), par8(raw[7:0])};
    endfunction

    // expected bit of half-symbol j (R6)
    function automatic logic exp_bit(input int j, input logic [15:0] pr);
        int b;
        if (j < 14) return (j % 2 == 0);
        b = (j - 14) / 2;
        if (b < 3) return (b == 2);
        return pr[b - 3];
    endfunction

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_pair(input logic f, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_fld = f; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pulses line_start and checks the whole line; optional colliding write and retrigger
    task automatic run_line(input string tag, input logic exp_on, input logic [15:0] pr,
                            input int ofs, input logic retrig, input logic col_wr,
                            input logic [15:0] col_data);
        int L;
        int wl;
        int bad_k;
        int bad_act;
        int bad_exp;
        logic pre_ok;
        int vcount;
        L  = std_625 ? 1728 : 1716;
        wl = std_625 ? 1404 : 1395;
        start_ofs = 11'(ofs);
        @(negedge clk);
        line_start = 1'b1;
        if (col_wr) begin
            wr_en = 1'b1; wr_fld = fld; wr_data = col_data;
        end
        @(negedge clk);
        line_start = 1'b0;
        wr_en = 1'b0;
        if (!exp_on) begin
            vcount = 0;
            for (int i = 0; i < 1600; i++) begin
                if (smp_vld || smp != 10'd0) vcount++;
                @(negedge clk);
            end
            check({tag, " R1/R10 no burst"}, vcount == 0, vcount, 0);
        end else begin
            pre_ok = 1'b1;
            for (int i = 0; i <= ofs; i++) begin
                if (smp_vld) pre_ok = 1'b0;
                @(negedge clk);
            end
            check({tag, " R2 low during offset"}, pre_ok, int'(!pre_ok), 0);
            bad_k = -1; bad_act = 0; bad_exp = 0;
            for (int k = 1; k <= wl; k++) begin
                int j;
                int e;
                j = (64 * (k - 1)) / L;
                e = exp_bit(j, pr) ? 560 : 240;
                if (bad_k < 0 && (!smp_vld || int'(smp) != e)) begin
                    bad_k = k; bad_act = smp_vld ? int'(smp) : -1; bad_exp = e;
                end
                if (retrig && k == 100) line_start = 1'b1;
                if (retrig && k == 101) line_start = 1'b0;
                @(negedge clk);
            end
            if (bad_k >= 0) $display("  %s first mismatch at burst clock %0d", tag, bad_k);
            check({tag, " R4/R5/R6/R7 waveform"}, bad_k < 0, bad_act, bad_exp);
            check({tag, " R3 burst ends"}, !smp_vld && smp == 10'd0, int'(smp_vld), 0);
        end
    endtask

    task automatic t_reset;
        check("R12 vld after reset", smp_vld == 1'b0, int'(smp_vld), 0);
        check("R12 smp after reset", smp == 10'd0, int'(smp), 0);
    endtask

    task automatic t_null_625;
        std_625 = 1'b1; line_num = 10'd22; fld = 1'b0;
        run_line("t_null_625 R9", 1'b1, 16'h8080, 5, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_data_625;
        // second byte written with bit 7 set, parity must override it (R7)
        write_pair(1'b0, 16'hC314);
        run_line("t_data_625 R8", 1'b1, enc_pair(16'h4314), 0, 1'b0, 1'b0, 16'h0);
        run_line("t_again_625 R9", 1'b1, 16'h8080, 3, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_field2_525;
        std_625 = 1'b0; line_num = 10'd21; fld = 1'b1;
        write_pair(1'b1, 16'h052A);
        run_line("t_field2_525 R3", 1'b1, enc_pair(16'h052A), 200, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_wrong_line;
        std_625 = 1'b0; fld = 1'b0; line_num = 10'd20;
        run_line("t_wrong_line R1", 1'b0, 16'h0, 0, 1'b0, 1'b0, 16'h0);
        line_num = 10'd22;
        run_line("t_625_line_in_525 R1", 1'b0, 16'h0, 0, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_disable;
        std_625 = 1'b1; line_num = 10'd22; fld = 1'b0; cap_en = 2'b10;
        write_pair(1'b0, 16'h2211);
        run_line("t_disable R10", 1'b0, 16'h0, 0, 1'b0, 1'b0, 16'h0);
        cap_en = 2'b11;
        run_line("t_reenable R10", 1'b1, enc_pair(16'h2211), 10, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic t_collision;
        std_625 = 1'b1; line_num = 10'd22; fld = 1'b1;
        write_pair(1'b1, 16'h4433);
        run_line("t_collision R8", 1'b1, enc_pair(16'h4433), 7, 1'b0, 1'b1, 16'h6655);
        run_line("t_after_coll R8 R11", 1'b1, enc_pair(16'h6655), 1, 1'b1, 1'b0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_null_625();
        t_data_625();
        t_field2_525();
        t_wrong_line();
        t_disable();
        t_collision();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule